// File: doc/BRIEF.md
# Oversampled Serial Receiver with Address-Qualified Interrupt

This block receives asynchronous serial frames on a single data line and delivers each character, in parallel, to a holding register. A free-running strobe at sixteen times the bit rate paces it. The character length can be set from five to eight bits. An optional extra bit after the data can carry an address flag or a ninth data bit. Characters are sent least-significant bit first. Positions above the selected length in the holding register read as ones.

Besides the plain data-ready flag, the block raises an address interrupt flag. When it raises this flag depends on one of four qualification modes. It also recognises a line break, where the line stays low for a complete frame. It flags a bad stop bit as a framing error. One mode uses the break: it accepts a matching character only if that character is the very next one after a break. Software clears every status flag with a single read-acknowledge pulse.

Top module: `serial_addr_rx`

## Requirements
- R1: A low level on the data line is taken as a start bit only if it is still low at the middle of the start bit. A shorter low pulse produces no character and no flag.
- R2: Data bits are received least-significant bit first. `word_len` values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Bits of `rx_word` at and above the selected length read as 1.
- R3: When `addr_bit_en` is 1, one extra bit follows the data bits and appears on `rx_bit9`. When `addr_bit_en` is 0, no extra bit is received and `rx_bit9` is 0.
- R4: The word, the ninth bit and all flags update together when the stop bit is sampled at its middle. A character that is not a break sets `data_ready`. After reset, all flags and `rx_word` are 0.
- R5: A frame whose stop bit is sampled low, and whose data and extra bits are not all zero, is still delivered, with `frame_err` set to 1. A frame with a high stop bit delivers `frame_err` 0.
- R6: A frame whose start, data, extra and stop bits are all low is a break. It sets `break_det`, and it leaves `rx_word` and `data_ready` unchanged. The receiver then waits for the line to go high before it looks for a new start bit.
- R7: With `amode_en` 1 and `amode` 0, a character sets `addr_irq` exactly when its received ninth bit is 1.
- R8: With `amode_en` 1 and `amode` 1, a character sets `addr_irq` exactly when the padded 8-bit `rx_word` equals `cmp_val`.
- R9: With `amode_en` 1 and `amode` 2, a character sets `addr_irq` exactly when it matches `cmp_val` and its ninth bit is 1.
- R10: With `amode_en` 1 and `amode` 3, a character sets `addr_irq` exactly when it matches `cmp_val` and is the first character after a break. Any delivered character, matching or not, disarms this condition.
- R11: With `amode_en` 0, `addr_irq` is never set.
- R12: A one-cycle `rd_ack` pulse clears `data_ready`, `addr_irq`, `break_det` and `frame_err` and leaves `rx_word` unchanged. A frame that ends in the same cycle takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Serial data line, idle high |
| tick16 | input | 1 | One-cycle strobe at sixteen times the bit rate |
| word_len | input | 2 | Data length select: 0..3 for 5..8 bits |
| addr_bit_en | input | 1 | Receive an extra ninth bit after the data |
| amode_en | input | 1 | Enable the address interrupt |
| amode | input | 2 | Address interrupt qualification mode |
| cmp_val | input | 8 | Character compare value |
| rd_ack | input | 1 | Clear all status flags |
| rx_word | output | 8 | Last received character, padded with ones |
| rx_bit9 | output | 1 | Ninth bit of the last character |
| data_ready | output | 1 | A character has been delivered |
| addr_irq | output | 1 | Address interrupt condition met |
| break_det | output | 1 | Line break received |
| frame_err | output | 1 | Stop bit of the last character was low |

## Verification
The bench builds the block with its default sixteen-times oversampling and a two-stage input synchroniser. The strobe fires every fourth clock, so a bit lasts 64 cycles. This short bit time lets a few dozen random frames run, covering every length, the ninth bit and all four modes. It also leaves room for directed breaks, stop-bit errors and a sub-half-bit start glitch. The compare value is often set to the character being sent, so the bench reaches both matching and non-matching characters. It also sends break, non-matching and matching characters in that order, which exercises the disarming of the after-break mode.

// File: rtl/addr_rx_pkg.sv
package addr_rx_pkg;

    localparam int WORD_W  = 8;
    localparam int MIN_LEN = 5;
    localparam int SH_W    = WORD_W + 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP,
        ST_HOLD
    } rx_state_e;

    typedef enum logic [1:0] {
        AM_NINTH       = 2'd0,
        AM_MATCH       = 2'd1,
        AM_MATCH_NINTH = 2'd2,
        AM_AFTER_BRK   = 2'd3
    } amode_e;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              bit9;
        logic              stop_err;
        logic              is_break;
    } rx_frame_t;

    // number of bits between start and stop
    function automatic logic [3:0] frame_bits(input logic [1:0] wl, input logic abit);
        return 4'(MIN_LEN) + {2'b00, wl} + {3'b000, abit};
    endfunction

    // keep the valid data bits, force the rest to one (R2)
    function automatic logic [WORD_W-1:0] pad_word(input logic [SH_W-1:0] sh,
                                                   input logic [1:0] wl);
        logic [WORD_W-1:0] w;
        for (int i = 0; i < WORD_W; i++)
            w[i] = (i < MIN_LEN + int'(wl)) ? sh[i] : 1'b1;
        return w;
    endfunction

    function automatic logic ninth_of(input logic [SH_W-1:0] sh, input logic [1:0] wl);
        return sh[MIN_LEN + int'(wl)];
    endfunction

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rx_frame.sv
module rx_frame
    import addr_rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       rx_in,
    input  logic [1:0] word_len,
    input  logic       addr_bit_en,
    output rx_frame_t  frm,
    output logic       frm_valid
);
    localparam int CNT_W = $clog2(OSR);
    localparam int MID   = OSR / 2 - 1;
    localparam int LAST  = OSR - 1;

    rx_state_e       state;
    logic [CNT_W-1:0] tcnt;
    logic [3:0]       bidx;
    logic [SH_W-1:0]  sh;
    logic [3:0]       last_idx;

    assign last_idx = frame_bits(word_len, addr_bit_en) - 4'd1;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            tcnt      <= '0;
            bidx      <= '0;
            sh        <= '0;
            frm       <= '0;
            frm_valid <= 1'b0;
        end else begin
            frm_valid <= 1'b0;
            if (tick) begin
                case (state)
                    ST_IDLE: begin
                        if (!rx_in) begin
                            state <= ST_START;
                            tcnt  <= '0;
                        end
                    end
                    ST_START: begin
                        // R1: confirm the start bit at mid-bit
                        if (tcnt == CNT_W'(MID)) begin
                            tcnt <= '0;
                            bidx <= '0;
                            sh   <= '0;
                            state <= rx_in ? ST_IDLE : ST_DATA;
                        end else begin
                            tcnt <= tcnt + CNT_W'(1);
                        end
                    end
                    ST_DATA: begin
                        if (tcnt == CNT_W'(LAST)) begin
                            tcnt     <= '0;
                            sh[bidx] <= rx_in;
                            if (bidx == last_idx) state <= ST_STOP;
                            else                  bidx  <= bidx + 4'd1;
                        end else begin
                            tcnt <= tcnt + CNT_W'(1);
                        end
                    end
                    ST_STOP: begin
                        if (tcnt == CNT_W'(LAST)) begin
                            tcnt          <= '0;
                            frm_valid     <= 1'b1;
                            frm.word      <= pad_word(sh, word_len);
                            frm.bit9      <= addr_bit_en & ninth_of(sh, word_len);
                            frm.stop_err  <= !rx_in;
                            frm.is_break  <= !rx_in && (sh == '0);
                            state         <= rx_in ? ST_IDLE : ST_HOLD;
                        end else begin
                            tcnt <= tcnt + CNT_W'(1);
                        end
                    end
                    ST_HOLD: begin
                        // R6: wait for the line to return high
                        if (rx_in) state <= ST_IDLE;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/rx_addr_qual.sv
module rx_addr_qual
    import addr_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frm_valid,
    input  logic [WORD_W-1:0] word,
    input  logic              bit9,
    input  logic              is_break,
    input  logic              amode_en,
    input  logic [1:0]        amode,
    input  logic [WORD_W-1:0] cmp_val,
    output logic              hit
);
    logic after_brk;
    logic match;
    logic cond;

    assign match = (word == cmp_val);

    always_comb begin
        case (amode_e'(amode))
            AM_NINTH:       cond = bit9;               // R7
            AM_MATCH:       cond = match;              // R8
            AM_MATCH_NINTH: cond = match && bit9;      // R9
            AM_AFTER_BRK:   cond = match && after_brk; // R10
            default:        cond = 1'b0;
        endcase
    end

    // R11: nothing qualifies while disabled
    assign hit = frm_valid && !is_break && amode_en && cond;

    // R10: armed by a break, disarmed by any delivered character
    always_ff @(posedge clk) begin
        if (rst)            after_brk <= 1'b0;
        else if (frm_valid) after_brk <= is_break;
    end
endmodule

// File: rtl/serial_addr_rx.sv
module serial_addr_rx
    import addr_rx_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rxd,
    input  logic       tick16,
    input  logic [1:0] word_len,
    input  logic       addr_bit_en,
    input  logic       amode_en,
    input  logic [1:0] amode,
    input  logic [7:0] cmp_val,
    input  logic       rd_ack,
    output logic [7:0] rx_word,
    output logic       rx_bit9,
    output logic       data_ready,
    output logic       addr_irq,
    output logic       break_det,
    output logic       frame_err
);
    logic      rx_s;
    rx_frame_t frm;
    logic      frm_valid;
    logic      hit;

    rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (rxd),
        .q   (rx_s)
    );

    rx_frame #(.OSR(OSR)) u_frame (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick16),
        .rx_in       (rx_s),
        .word_len    (word_len),
        .addr_bit_en (addr_bit_en),
        .frm         (frm),
        .frm_valid   (frm_valid)
    );

    rx_addr_qual u_qual (
        .clk       (clk),
        .rst       (rst),
        .frm_valid (frm_valid),
        .word      (frm.word),
        .bit9      (frm.bit9),
        .is_break  (frm.is_break),
        .amode_en  (amode_en),
        .amode     (amode),
        .cmp_val   (cmp_val),
        .hit       (hit)
    );

    // R4/R12: all state updates at the transfer; a frame end beats rd_ack
    always_ff @(posedge clk) begin
        if (rst) begin
            rx_word    <= '0;
            rx_bit9    <= 1'b0;
            data_ready <= 1'b0;
            addr_irq   <= 1'b0;
            break_det  <= 1'b0;
            frame_err  <= 1'b0;
        end else begin
            if (rd_ack) begin
                data_ready <= 1'b0;
                addr_irq   <= 1'b0;
                break_det  <= 1'b0;
                frame_err  <= 1'b0;
            end
            if (frm_valid) begin
                if (frm.is_break) begin
                    break_det <= 1'b1;
                end else begin
                    rx_word    <= frm.word;
                    rx_bit9    <= frm.bit9;
                    data_ready <= 1'b1;
                    frame_err  <= frm.stop_err;
                    addr_irq   <= hit;
                end
            end
        end
    end
endmodule

// File: rtl/serial_addr_rx_chk.sv
module serial_addr_rx_chk (
    input logic       clk,
    input logic       rst,
    input logic       rd_ack,
    input logic       frm_valid,
    input logic       data_ready,
    input logic       addr_irq,
    input logic       break_det,
    input logic       frame_err,
    input logic       amode_en,
    input logic [1:0] amode,
    input logic [1:0] word_len,
    input logic       addr_bit_en,
    input logic [7:0] rx_word,
    input logic       rx_bit9
);
    // R12
    ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
        rd_ack && !frm_valid |=> !data_ready && !addr_irq && !break_det && !frame_err);

    // R4
    ready_on_xfer_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(data_ready) |-> $past(frm_valid));

    // R6
    break_on_xfer_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(break_det) |-> $past(frm_valid));

    // R2
    pad_ones_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(data_ready) && word_len == 2'd0 |-> rx_word[7:5] == 3'b111);

    // R3
    no_ninth_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(data_ready) && !addr_bit_en |-> !rx_bit9);

    // R11
    irq_enabled_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(addr_irq) |-> $past(amode_en));

    // R7
    mode0_ninth_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(addr_irq) && amode == 2'd0 |-> rx_bit9);

    // R9
    mode2_ninth_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(addr_irq) && amode == 2'd2 |-> rx_bit9);

    // R4
    irq_with_ready_chk: assert property (@(posedge clk) disable iff (rst)
        addr_irq |-> data_ready);
endmodule

bind serial_addr_rx serial_addr_rx_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .rd_ack      (rd_ack),
    .frm_valid   (frm_valid),
    .data_ready  (data_ready),
    .addr_irq    (addr_irq),
    .break_det   (break_det),
    .frame_err   (frame_err),
    .amode_en    (amode_en),
    .amode       (amode),
    .word_len    (word_len),
    .addr_bit_en (addr_bit_en),
    .rx_word     (rx_word),
    .rx_bit9     (rx_bit9)
);

// File: tb/serial_addr_rx_tb.sv
module serial_addr_rx_tb;
    localparam int TD     = 4;
    localparam int BITCLK = 16 * TD;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rxd = 1'b1;
    logic       tick16 = 1'b0;
    logic [1:0] word_len = 2'd3;
    logic       addr_bit_en = 1'b0;
    logic       amode_en = 1'b0;
    logic [1:0] amode = 2'd0;
    logic [7:0] cmp_val = 8'h00;
    logic       rd_ack = 1'b0;
    logic [7:0] rx_word;
    logic       rx_bit9, data_ready, addr_irq, break_det, frame_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    bit after_brk_m = 1'b0;
    logic [7:0] last_word = 8'h00;
    int tcount = 0;

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        if (tcount == TD - 1) begin tcount <= 0; tick16 <= 1'b1; end
        else begin tcount <= tcount + 1; tick16 <= 1'b0; end
    end

    serial_addr_rx u_dut (
        .clk(clk), .rst(rst), .rxd(rxd), .tick16(tick16), .word_len(word_len),
        .addr_bit_en(addr_bit_en), .amode_en(amode_en), .amode(amode),
        .cmp_val(cmp_val), .rd_ack(rd_ack), .rx_word(rx_word), .rx_bit9(rx_bit9),
        .data_ready(data_ready), .addr_irq(addr_irq), .break_det(break_det),
        .frame_err(frame_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_word(input logic [8:0] d, input logic [1:0] wl);
        logic [7:0] w;
        for (int i = 0; i < 8; i++) w[i] = (i < 5 + int'(wl)) ? d[i] : 1'b1;
        return w;
    endfunction

    task automatic send_bit(input logic b);
        rxd = b;
        repeat (BITCLK) @(negedge clk);
    endtask

    task automatic do_ack();
        @(negedge clk) rd_ack = 1'b1;
        @(negedge clk) rd_ack = 1'b0;
        @(negedge clk);
        chk("R12 data_ready cleared", int'(data_ready), 0);
        chk("R12 addr_irq cleared", int'(addr_irq), 0);
        chk("R12 break_det cleared", int'(break_det), 0);
        chk("R12 frame_err cleared", int'(frame_err), 0);
        chk("R12 word kept", int'(rx_word), int'(last_word));
    endtask

    task automatic run_frame(input logic [8:0] d, input logic stop);
        int n;
        logic [7:0] ew;
        logic eb9, match, hit;
        string irq_tag;
        n = 5 + int'(word_len);
        send_bit(1'b0);
        for (int i = 0; i < n; i++) send_bit(d[i]);
        if (addr_bit_en) send_bit(d[8]);
        send_bit(stop);
        send_bit(1'b1);
        ew    = exp_word(d, word_len);
        eb9   = addr_bit_en & d[8];
        match = (ew == cmp_val);
        case (amode)
            2'd0: begin hit = eb9;                 irq_tag = "R7"; end
            2'd1: begin hit = match;               irq_tag = "R8"; end
            2'd2: begin hit = match && eb9;        irq_tag = "R9"; end
            default: begin hit = match && after_brk_m; irq_tag = "R10"; end
        endcase
        if (!amode_en) begin hit = 1'b0; irq_tag = "R11"; end
        chk("R4 data_ready", int'(data_ready), 1);
        chk("R2 word", int'(rx_word), int'(ew));
        chk("R3 ninth bit", int'(rx_bit9), int'(eb9));
        chk({irq_tag, " addr_irq"}, int'(addr_irq), int'(hit));
        chk("R5 frame_err", int'(frame_err), int'(!stop));
        chk("R6 no break on data", int'(break_det), 0);
        after_brk_m = 1'b0;
        last_word   = ew;
        do_ack();
    endtask

    task automatic send_break();
        int n;
        n = 2 + int'(frame_bits_tb()) + 2;
        for (int i = 0; i < n; i++) send_bit(1'b0);
        send_bit(1'b1);
        send_bit(1'b1);
        chk("R6 break_det", int'(break_det), 1);
        chk("R6 no data_ready", int'(data_ready), 0);
        chk("R6 word unchanged", int'(rx_word), int'(last_word));
        after_brk_m = 1'b1;
        do_ack();
    endtask

    function automatic int frame_bits_tb();
        return 5 + int'(word_len) + int'(addr_bit_en);
    endfunction

    initial begin
        logic [8:0] d;
        logic st;
        int r;
        r = int'($urandom(32'd20240611));
        repeat (10) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R4 reset data_ready", int'(data_ready), 0);
        chk("R4 reset addr_irq", int'(addr_irq), 0);
        chk("R4 reset break_det", int'(break_det), 0);
        chk("R4 reset frame_err", int'(frame_err), 0);
        chk("R4 reset word", int'(rx_word), 0);

        // R1: short low glitch
        rxd = 1'b0;
        repeat (2 * TD) @(negedge clk);
        rxd = 1'b1;
        repeat (3 * BITCLK) @(negedge clk);
        chk("R1 glitch ignored", int'(data_ready), 0);

        // R2: lengths
        word_len = 2'd3; run_frame(9'h0A5, 1'b1);
        word_len = 2'd0; run_frame(9'h013, 1'b1);
        word_len = 2'd2; run_frame(9'h055, 1'b1);

        // R3 / R7
        word_len = 2'd3; addr_bit_en = 1'b1; amode_en = 1'b1; amode = 2'd0;
        run_frame(9'h131, 1'b1);
        run_frame(9'h031, 1'b1);

        // R8
        amode = 2'd1; cmp_val = 8'h3C;
        run_frame(9'h03C, 1'b1);
        run_frame(9'h03D, 1'b1);

        // R9
        amode = 2'd2;
        run_frame(9'h13C, 1'b1);
        run_frame(9'h03C, 1'b1);

        // R5
        run_frame(9'h081, 1'b0);

        // R6 / R10
        amode = 2'd3;
        send_break();
        run_frame(9'h03C, 1'b1);
        run_frame(9'h03C, 1'b1);
        send_break();
        run_frame(9'h011, 1'b1);
        run_frame(9'h03C, 1'b1);

        // R11
        amode_en = 1'b0; amode = 2'd1;
        run_frame(9'h13C, 1'b1);

        // random mix
        for (int k = 0; k < 40; k++) begin
            word_len    = 2'($urandom_range(0, 3));
            addr_bit_en = 1'($urandom_range(0, 1));
            amode_en    = ($urandom_range(0, 4) != 0);
            amode       = 2'($urandom_range(0, 3));
            d           = 9'($urandom);
            cmp_val     = ($urandom_range(0, 1) != 0) ? exp_word(d, word_len) : 8'($urandom);
            st          = ($urandom_range(0, 7) != 0);
            if (!st) d[0] = 1'b1;
            if ($urandom_range(0, 9) == 0) send_break();
            run_frame(d, st);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule